// File: doc/BRIEF.md
# Delayed-Carry Relaxed Add-Compare-Select

This block is a single add-compare-select cell for one state of a radix-2 trellis. Each cycle where the valid strobe is high, it adds a 4-bit branch metric to each of two incoming path metrics. It then picks the smaller candidate and registers that candidate as the state's new path metric, together with a one-bit decision that says which branch won.

The cell is built for a short critical path, and it gets there in two ways.

- **Deferred carry.** The 8-bit metric is split into a low nibble and a high nibble. The carry out of the low-nibble addition is not propagated in the same cycle. It is stored as a ninth metric bit, and the next cell that consumes the metric folds it into the high nibble.
- **Relaxed compare.** The high-nibble sums alone decide the selection. A 5-bit compare of the low sums is used only when the high sums are equal.

As a result, a near-tie may occasionally be resolved the wrong way. Such a mistake can only happen when the two true metrics are less than 16 apart.

Metrics are carried in a 9-bit delayed-carry form and may wrap modulo 256 as two's complement values. Neighbouring cells feed their registered outputs into `pm_i`/`pm_j` of this cell.

Top module: `dcacs_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next state of `pm_out` is all zeros (pending carry cleared) and `pick_j` is 0.
- R2: At a clock edge where `in_valid` is low and `rst` is low, `pm_out` and `pick_j` keep their values.
- R3: Metric encoding is bits [3:0] low nibble, bits [7:4] high nibble, bit 8 pending carry. When a candidate is formed:
  - its low nibble is (input low + branch metric) mod 16;
  - its bit 8 is the carry out of that 4-bit addition;
  - its high nibble is (input high + input bit 8) mod 16.

  The new low-section carry is not added into the high nibble in the same cycle.
- R4: The resolved value of `pm_out` (bits [7:0] plus 16 times bit 8, mod 256) equals the resolved input metric of the chosen branch plus its branch metric, mod 256.
- R5: When the two candidates' high nibbles differ, the choice depends only on the sign of their 4-bit modular difference. Branch i is chosen when (high_i - high_j) mod 16 is 8 or more; otherwise branch j is chosen. Metric wrap is handled the same way.
- R6: When the two high nibbles are equal, the 5-bit low sums (nibble plus carry-out) decide the choice. Branch j is chosen only if its low sum is strictly smaller.
- R7: `pick_j` is 0 when branch i is chosen and 1 when branch j is chosen. If the candidates are exactly equal, branch i is chosen.
- R8: Whenever the choice differs from that of an exact comparator of resolved metrics (with ties going to i), the two resolved candidate metrics differ by less than 16 in signed modulo-256 terms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Update strobe; state changes only when high |
| pm_i | input | 9 | Path metric of branch i, delayed-carry form |
| pm_j | input | 9 | Path metric of branch j, delayed-carry form |
| bm_i | input | 4 | Unsigned branch metric of branch i |
| bm_j | input | 4 | Unsigned branch metric of branch j |
| pm_out | output | 9 | Registered survivor metric, delayed-carry form |
| pick_j | output | 1 | Registered decision, 1 when branch j won |

## Verification
The table patterns each separate one decision path:
- high nibbles apart in either direction;
- equal high nibbles with a strict low winner;
- an exact tie, which must go to i;
- a pending input carry that changes the high sum;
- a low-section overflow that must show up in bit 8 rather than in the high nibble;
- a wrapped pair that an unsigned compare would order wrongly;
- the one known mis-selection case.

A long run of close random metric pairs then confirms that the resolved output always equals the chosen branch's exact sum. It also confirms that every disagreement with an ideal comparator stays within the 16 bound. Directed steps cover the idle hold and a reset in the middle of a run.

// File: rtl/dcacs_pkg.sv
package dcacs_pkg;
  localparam int unsigned LO_W_DEF = 4;
  localparam int unsigned HI_W_DEF = 4;
  typedef enum logic {PICK_I = 1'b0, PICK_J = 1'b1} pick_e;
endpackage

// File: rtl/dcacs_split_add.sv
module dcacs_split_add #(
  parameter int unsigned LO_W = dcacs_pkg::LO_W_DEF,
  parameter int unsigned HI_W = dcacs_pkg::HI_W_DEF,
  localparam int unsigned PM_W = LO_W + HI_W + 1
) (
  input  logic [PM_W-1:0] pm_in,
  input  logic [LO_W-1:0] bm,
  output logic [PM_W-1:0] cand,
  output logic [LO_W:0]   lo_ext,
  output logic [HI_W-1:0] hi_sum
);
  // low section: nibble plus branch metric, carry kept as extra bit
  function automatic logic [LO_W:0] lo_add(input logic [LO_W-1:0] a, input logic [LO_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // high section: fold in the carry saved by the previous stage
  function automatic logic [HI_W-1:0] hi_fold(input logic [HI_W-1:0] h, input logic c);
    return h + {{(HI_W-1){1'b0}}, c};
  endfunction

  always_comb begin
    lo_ext = lo_add(pm_in[LO_W-1:0], bm);
    hi_sum = hi_fold(pm_in[LO_W+HI_W-1:LO_W], pm_in[PM_W-1]);
    cand   = {lo_ext[LO_W], hi_sum, lo_ext[LO_W-1:0]};
  end
endmodule

// File: rtl/dcacs_relaxed_cmp.sv
module dcacs_relaxed_cmp #(
  parameter int unsigned LO_W = dcacs_pkg::LO_W_DEF,
  parameter int unsigned HI_W = dcacs_pkg::HI_W_DEF
) (
  input  logic [HI_W-1:0] hi_i,
  input  logic [HI_W-1:0] hi_j,
  input  logic [LO_W:0]   lo_i,
  input  logic [LO_W:0]   lo_j,
  output logic            hi_eq,
  output logic            hi_pick_j,
  output logic            lo_pick_j,
  output logic            pick_j
);
  // j wins the high compare when i - j is nonzero with a clear sign bit
  function automatic logic hi_j_smaller(input logic [HI_W-1:0] a, input logic [HI_W-1:0] b);
    logic [HI_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[HI_W-1];
  endfunction

  always_comb begin
    hi_eq     = (hi_i == hi_j);
    hi_pick_j = hi_j_smaller(hi_i, hi_j);
    lo_pick_j = (lo_j < lo_i);
    pick_j    = hi_eq ? lo_pick_j : hi_pick_j;
  end
endmodule

// File: rtl/dcacs_unit.sv
module dcacs_unit #(
  parameter int unsigned LO_W = dcacs_pkg::LO_W_DEF,
  parameter int unsigned HI_W = dcacs_pkg::HI_W_DEF,
  localparam int unsigned PM_W = LO_W + HI_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [PM_W-1:0] pm_i,
  input  logic [PM_W-1:0] pm_j,
  input  logic [LO_W-1:0] bm_i,
  input  logic [LO_W-1:0] bm_j,
  output logic [PM_W-1:0] pm_out,
  output logic            pick_j
);
  localparam int unsigned NBR = 2;

  logic [PM_W-1:0] pm_v   [NBR];
  logic [LO_W-1:0] bm_v   [NBR];
  logic [PM_W-1:0] cand_v [NBR];
  logic [LO_W:0]   lo_v   [NBR];
  logic [HI_W-1:0] hi_v   [NBR];

  assign pm_v[0] = pm_i;
  assign pm_v[1] = pm_j;
  assign bm_v[0] = bm_i;
  assign bm_v[1] = bm_j;

  for (genvar g = 0; g < NBR; g++) begin : g_branch
    dcacs_split_add #(.LO_W(LO_W), .HI_W(HI_W)) u_add (
      .pm_in (pm_v[g]),
      .bm    (bm_v[g]),
      .cand  (cand_v[g]),
      .lo_ext(lo_v[g]),
      .hi_sum(hi_v[g])
    );
  end

  // named internal events for the checker
  logic [PM_W-1:0] cand_i_w, cand_j_w;
  logic [LO_W:0]   lo_i_w, lo_j_w;
  logic            hi_eq_w, hi_pick_j_w, lo_pick_j_w, pick_j_w;

  assign cand_i_w = cand_v[0];
  assign cand_j_w = cand_v[1];
  assign lo_i_w   = lo_v[0];
  assign lo_j_w   = lo_v[1];

  dcacs_relaxed_cmp #(.LO_W(LO_W), .HI_W(HI_W)) u_cmp (
    .hi_i     (hi_v[0]),
    .hi_j     (hi_v[1]),
    .lo_i     (lo_v[0]),
    .lo_j     (lo_v[1]),
    .hi_eq    (hi_eq_w),
    .hi_pick_j(hi_pick_j_w),
    .lo_pick_j(lo_pick_j_w),
    .pick_j   (pick_j_w)
  );

  logic [PM_W-1:0] pm_next;
  assign pm_next = pick_j_w ? cand_j_w : cand_i_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_out <= '0;
      pick_j <= dcacs_pkg::PICK_I;
    end else if (in_valid) begin
      pm_out <= pm_next;
      pick_j <= pick_j_w;
    end
  end
endmodule

// File: rtl/dcacs_unit_chk.sv
module dcacs_unit_chk #(
  parameter int unsigned LO_W = dcacs_pkg::LO_W_DEF,
  parameter int unsigned HI_W = dcacs_pkg::HI_W_DEF,
  localparam int unsigned PM_W = LO_W + HI_W + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [PM_W-1:0] pm_out,
  input logic            pick_j,
  input logic [PM_W-1:0] cand_i_w,
  input logic [PM_W-1:0] cand_j_w,
  input logic [LO_W:0]   lo_i_w,
  input logic [LO_W:0]   lo_j_w,
  input logic            hi_eq_w,
  input logic            hi_pick_j_w,
  input logic            lo_pick_j_w,
  input logic            pick_j_w
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pm_out == '0 && pick_j == 1'b0));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(pm_out) && $stable(pick_j)));

  assert_carry_saved_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> pm_out[PM_W-1] == $past(pick_j_w ? lo_j_w[LO_W] : lo_i_w[LO_W]));

  assert_high_decides_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hi_eq_w) |=> pick_j == $past(hi_pick_j_w));

  assert_low_breaks_tie_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hi_eq_w) |=> pick_j == $past(lo_pick_j_w));

  assert_tie_keeps_i_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cand_i_w == cand_j_w) |=> !pick_j);
endmodule

bind dcacs_unit dcacs_unit_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .pm_out     (pm_out),
  .pick_j     (pick_j),
  .cand_i_w   (cand_i_w),
  .cand_j_w   (cand_j_w),
  .lo_i_w     (lo_i_w),
  .lo_j_w     (lo_j_w),
  .hi_eq_w    (hi_eq_w),
  .hi_pick_j_w(hi_pick_j_w),
  .lo_pick_j_w(lo_pick_j_w),
  .pick_j_w   (pick_j_w)
);

// File: tb/sim_dcacs_unit.sv
`timescale 1ns/1ps
module sim_dcacs_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [8:0] pm_i = '0, pm_j = '0;
  logic [3:0] bm_i = '0, bm_j = '0;
  logic [8:0] pm_out;
  logic       pick_j;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dcacs_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .pm_i(pm_i), .pm_j(pm_j), .bm_i(bm_i), .bm_j(bm_j),
    .pm_out(pm_out), .pick_j(pick_j)
  );

  // {pm_i, pm_j, bm_i, bm_j, expected pm_out, expected pick_j}
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {9'h010, 9'h020, 4'd1,  4'd1, 9'h011, 1'b0},  // R5 high i smaller
    {9'h050, 9'h030, 4'd0,  4'd0, 9'h030, 1'b1},  // R5 high j smaller
    {9'h045, 9'h047, 4'd3,  4'd0, 9'h047, 1'b1},  // R6 low decides
    {9'h045, 9'h047, 4'd2,  4'd0, 9'h047, 1'b0},  // R7 exact tie to i
    {9'h13F, 9'h050, 4'd1,  4'd5, 9'h140, 1'b0},  // R3 pending carry and new carry
    {9'h020, 9'h01F, 4'd0,  4'd15, 9'h11E, 1'b1}, // R8 known mis-selection
    {9'h0F0, 9'h010, 4'd0,  4'd0, 9'h0F0, 1'b0},  // R5 wrapped pair
    {9'h110, 9'h025, 4'd4,  4'd0, 9'h024, 1'b0}   // R3 folded carry, R6 tie-break
  };
  localparam string TAGS [NV] = '{"R5", "R5", "R6", "R7", "R3", "R8", "R5", "R3"};

  function automatic int resolve(input logic [8:0] v);
    return (int'(v[7:0]) + (v[8] ? 16 : 0)) % 256;
  endfunction

  function automatic int sdiff(input int a, input int b);
    int d;
    d = (a - b + 512) % 256;
    return (d >= 128) ? d - 256 : d;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [8:0] a, input logic [8:0] b,
                      input logic [3:0] ba, input logic [3:0] bb);
    @(negedge clk);
    in_valid = v; pm_i = a; pm_j = b; bm_i = ba; bm_j = bb;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset metric", int'(pm_out), 0);
    check("R1 reset pick", int'(pick_j), 0);
    @(negedge clk); rst = 1'b0;

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [35:0] e;
      e = VEC[k];
      step(1'b1, e[35:27], e[26:18], e[17:14], e[13:10]);
      check({TAGS[k], " metric"}, int'(pm_out), int'(e[9:1]));
      check({TAGS[k], " pick"}, int'(pick_j), int'(e[0]));
      check("R4 resolved", resolve(pm_out),
            (resolve(e[0] ? e[26:18] : e[35:27]) + int'(e[0] ? e[13:10] : e[17:14])) % 256);
    end

    // R2: inputs change with strobe low, outputs hold
    begin
      logic [8:0] held;
      logic       hp;
      held = pm_out; hp = pick_j;
      step(1'b0, 9'h1AA, 9'h033, 4'd9, 4'd2);
      check("R2 idle metric", int'(pm_out), int'(held));
      check("R2 idle pick", int'(pick_j), int'(hp));
    end

    // random close pairs: R3, R4, R8
    for (int n = 0; n < 400; n++) begin
      logic [8:0] a, b;
      logic [3:0] ba, bb;
      int ta, tb, ca, cb, off, rsel, lo;
      a = 9'($urandom); ba = 4'($urandom); bb = 4'($urandom);
      off = int'($urandom % 81) - 40;
      b[8] = 1'($urandom);
      b[7:0] = 8'((resolve(a) + off - (b[8] ? 16 : 0) + 512) % 256);
      step(1'b1, a, b, ba, bb);
      ca = (resolve(a) + int'(ba)) % 256;
      cb = (resolve(b) + int'(bb)) % 256;
      rsel = pick_j ? cb : ca;
      check("R4 random resolved", resolve(pm_out), rsel);
      lo = pick_j ? int'(b[3:0]) + int'(bb) : int'(a[3:0]) + int'(ba);
      check("R3 random carry bit", int'(pm_out[8]), lo / 16);
      if (int'(pick_j) != ((sdiff(cb, ca) < 0) ? 1 : 0)) begin
        int m;
        m = sdiff(cb, ca);
        if (m < 0) m = -m;
        check("R8 mismatch within 16", (m < 16) ? 1 : 0, 1);
      end
    end

    // R1 reset mid-run
    step(1'b1, 9'h077, 9'h066, 4'd3, 4'd3);
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R1 mid reset metric", int'(pm_out), 0);
    check("R1 mid reset pick", int'(pick_j), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule